// File: doc/BRIEF.md
# Dual Clock Frequency Comparator

This block compares a clock under test against a reference clock. Each clock drives its own down-counter, and each counter is loaded from a seed that software programs. The reference-side counter sets how many reference cycles must pass before the test clock's count may finish. A second reference-side count then opens a tolerance window. The test clock passes if its counter reaches zero inside that window. It fails if the counter reaches zero before the window opens, or if the window closes first.

Software drives the block through a synchronous write port in the reference domain. It writes the two seeds and the window length, then starts a run by writing the control word with the enable bit set. In one-shot mode the block makes a single measurement, raises a sticky done flag and stops. In repeat mode every passing measurement reloads all three counts and starts again. The first failure stops the block until software starts it again.

The start request reaches the test-clock domain as a toggle through a two-flop synchroniser. The test counter's load acknowledge and its zero flag come back through two-flop synchronisers of their own. The reference side only accepts the zero flag once the acknowledge for the current run has been seen. A stale zero from an earlier run therefore cannot be counted.

Top module: `clk_ratio_monitor`

## Requirements
- R1: After reset, done, err and err_irq are 0 and nothing runs. Seeds written without the enable bit start no measurement, so no status changes.
- R2: The write port decodes wr_addr as follows: 0 is the control word, 1 is the reference seed, 2 is the window length and 3 is the test seed. Control bit 0 is enable, bit 1 is mode (1 = repeat, 0 = one-shot) and bit 2 is clear. A control write with bit 0 set starts a fresh measurement. A control write with bit 0 clear stops the block.
- R3: If the test counter's zero is seen while the window is open, a one-shot run ends with done = 1 and err = 0.
- R4: If the test counter's zero is seen before the reference counter has expired, err is set. In one-shot mode done is set as well.
- R5: If the window count expires before the test counter's zero is seen, err is set. In one-shot mode done is set as well.
- R6: Each detected failure produces exactly one err_irq pulse, one reference cycle long, in the same cycle that err becomes 1.
- R7: After a one-shot run ends, no further measurement takes place until the next start. Writing new seeds does not restart it.
- R8: In repeat mode a pass reloads all counters from the current seeds and measures again. done stays 0. A changed test seed takes effect at the next reload.
- R9: In repeat mode a failure sets err and halts measuring, so no further pulses occur. A new start resumes measuring.
- R10: done and err hold their value until a control write with bit 2 set clears both.
- R11: A control write with the enable bit clear aborts the measurement in progress. The aborted run never sets done or err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; also clocks the write port and the status outputs |
| clk_tst | input | 1 | Clock under test |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| done | output | 1 | Sticky: a one-shot measurement has ended |
| err | output | 1 | Sticky: a frequency failure was detected |
| err_irq | output | 1 | One-cycle pulse on each failure |

## Verification
Some properties are checked by assertions on every reference cycle. The interrupt pulse lasts one cycle and never appears without err. done and err fall only after a clear write. done rises only into the idle state. err rises only out of a running state. A stop write always leaves the block idle. Other behaviour depends on the real ratio of the two clocks, so only the bench scenarios can show it. These are the pass, early and late verdicts across sweeps of the test seed, reload with a new seed in repeat mode, the halt after a repeat-mode failure, and the abort by a stop write.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEED0 = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_WIN   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_SEED1 = 2'd3;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_MOD = 1;
    localparam int CTRL_CLR = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_WINDOW = 2'd2
    } mon_state_e;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_REPEAT  = 1'b1
    } mon_mode_e;

    typedef struct packed {
        logic      clr;
        mon_mode_e mode;
        logic      en;
    } ctrl_t;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_PASS = 2'd1,
        RES_FAIL = 2'd2
    } mon_result_e;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
    import clkmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  seed0,
    output logic [CNT_W-1:0]  win,
    output logic [CNT_W-1:0]  seed1,
    output mon_mode_e         mode,
    output logic              start_req,
    output logic              stop_req,
    output logic              clr_req
);
    ctrl_t ctrl_w;
    logic  ctrl_wr;

    assign ctrl_w  = ctrl_t'(wr_data[2:0]);
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            seed0 <= '0;
            win   <= '0;
            seed1 <= '0;
            mode  <= MODE_ONESHOT;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:  mode  <= ctrl_w.mode;
                ADDR_SEED0: seed0 <= wr_data;
                ADDR_WIN:   win   <= wr_data;
                default:    seed1 <= wr_data;
            endcase
        end
    end

    assign start_req = ctrl_wr && ctrl_w.en;
    assign stop_req  = ctrl_wr && !ctrl_w.en;
    assign clr_req   = ctrl_wr && ctrl_w.clr;
endmodule

// File: rtl/clkmon_tgt.sv
module clkmon_tgt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_tgl,
    input  logic [CNT_W-1:0] seed1,
    output logic             ack_tag,
    output logic             zero_flag
);
    logic             tgl_prev_q;
    logic             running_q;
    logic [CNT_W-1:0] cnt1_q;
    logic             load;

    assign load = start_tgl != tgl_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_prev_q <= 1'b0;
            running_q  <= 1'b0;
            cnt1_q     <= '0;
            ack_tag    <= 1'b0;
            zero_flag  <= 1'b0;
        end else begin
            tgl_prev_q <= start_tgl;
            if (load) begin
                cnt1_q    <= seed1;
                running_q <= 1'b1;
                ack_tag   <= start_tgl;
                zero_flag <= 1'b0;
            end else if (running_q) begin
                if (cnt1_q == '0) begin
                    zero_flag <= 1'b1;
                    running_q <= 1'b0;
                end else begin
                    cnt1_q <= cnt1_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clkmon_ref.sv
module clkmon_ref
    import clkmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             clr_req,
    input  mon_mode_e        mode,
    input  logic [CNT_W-1:0] seed0,
    input  logic [CNT_W-1:0] win,
    input  logic             ack_sync,
    input  logic             zero_sync,
    output logic             start_tgl,
    output mon_state_e       state,
    output logic             done,
    output logic             err,
    output logic             err_irq
);
    logic [CNT_W-1:0] cnt0_q;
    logic [CNT_W-1:0] wcnt_q;
    logic             armed, armed_q, hit;
    mon_result_e      res;
    logic             do_load;

    assign armed = (ack_sync == start_tgl);
    assign hit   = armed && armed_q && zero_sync;

    always_comb begin
        res = RES_NONE;
        case (state)
            ST_COUNT:  if (hit) res = RES_FAIL;
            ST_WINDOW: if (hit) res = RES_PASS;
                       else if (wcnt_q == '0) res = RES_FAIL;
            default:   res = RES_NONE;
        endcase
        if (start_req || stop_req) res = RES_NONE;
    end

    assign do_load = start_req ||
                     ((res == RES_PASS) && (mode == MODE_REPEAT) && !stop_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt0_q    <= '0;
            wcnt_q    <= '0;
            start_tgl <= 1'b0;
            armed_q   <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_irq   <= 1'b0;
        end else begin
            err_irq <= 1'b0;
            armed_q <= armed;
            if (clr_req) begin
                done <= 1'b0;
                err  <= 1'b0;
            end
            if (do_load) begin
                cnt0_q    <= seed0;
                wcnt_q    <= win;
                start_tgl <= ~start_tgl;
                armed_q   <= 1'b0;
                state     <= ST_COUNT;
            end else if (stop_req) begin
                state <= ST_IDLE;
            end else if (res == RES_FAIL) begin
                err     <= 1'b1;
                err_irq <= 1'b1;
                if (mode == MODE_ONESHOT) done <= 1'b1;
                state   <= ST_IDLE;
            end else if (res == RES_PASS) begin
                done  <= 1'b1;
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_COUNT:  if (cnt0_q == '0) state <= ST_WINDOW;
                               else cnt0_q <= cnt0_q - 1'b1;
                    ST_WINDOW: wcnt_q <= wcnt_q - 1'b1;
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
    import clkmon_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_ref,
    input  logic              clk_tst,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              done,
    output logic              err,
    output logic              err_irq
);
    logic [CNT_W-1:0] seed0, win, seed1;
    mon_mode_e        mode;
    mon_state_e       state;
    logic             start_req, stop_req, clr_req;
    logic             start_tgl, tgl_tst;
    logic             ack_tag, zero_flag, ack_sync, zero_sync;

    clkmon_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk_ref), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seed0(seed0), .win(win), .seed1(seed1),
        .mode(mode), .start_req(start_req), .stop_req(stop_req),
        .clr_req(clr_req)
    );

    clkmon_ref #(.CNT_W(CNT_W)) u_ref (
        .clk(clk_ref), .rst(rst), .start_req(start_req),
        .stop_req(stop_req), .clr_req(clr_req), .mode(mode),
        .seed0(seed0), .win(win), .ack_sync(ack_sync),
        .zero_sync(zero_sync), .start_tgl(start_tgl), .state(state),
        .done(done), .err(err), .err_irq(err_irq)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
        .clk(clk_tst), .rst(rst), .d(start_tgl), .q(tgl_tst)
    );

    clkmon_tgt #(.CNT_W(CNT_W)) u_tgt (
        .clk(clk_tst), .rst(rst), .start_tgl(tgl_tst), .seed1(seed1),
        .ack_tag(ack_tag), .zero_flag(zero_flag)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk_ref), .rst(rst), .d(ack_tag), .q(ack_sync)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync_zero (
        .clk(clk_ref), .rst(rst), .d(zero_flag), .q(zero_sync)
    );
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker
    import clkmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              done,
    input logic              err,
    input logic              err_irq,
    input mon_state_e        state
);
    logic clr_wr;
    logic stop_wr;
    assign clr_wr  = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_CLR];
    assign stop_wr = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[CTRL_EN];

    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        err_irq |=> !err_irq);

    assert_irq_with_err_R6: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(clr_wr));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(clr_wr));

    assert_done_stops_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (state == ST_IDLE));

    assert_err_from_run_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(state) != ST_IDLE));

    assert_stop_idles_R11: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> (state == ST_IDLE));
endmodule

bind clk_ratio_monitor clkmon_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk_ref), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err), .err_irq(err_irq),
    .state(state)
);

// File: tb/clk_ratio_monitor_tb.sv
`timescale 1ns/1ps
module clk_ratio_monitor_tb;
    localparam int CNT_W = 16;
    localparam int P0_PS = 8000;
    localparam int P1_PS = 10000;
    localparam int GUARD = 3;

    logic             clk_ref = 1'b0;
    logic             clk_tst = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             done, err, err_irq;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #4 clk_ref = ~clk_ref;
    always #5 clk_tst = ~clk_tst;

    clk_ratio_monitor #(.CNT_W(CNT_W)) u_dut (
        .clk_ref(clk_ref), .clk_tst(clk_tst), .rst(rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err),
        .err_irq(err_irq)
    );

    always @(negedge clk_ref) if (!rst && err_irq) irq_cnt++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk_ref);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = CNT_W'(data);
        @(negedge clk_ref);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    // 0 = pass, 1 = early, 2 = late, 3 = too close to a boundary
    function automatic int classify(input int s0, input int w, input int s1);
        int m, lo, hi;
        m  = 3 + ((s1 + 4) * P1_PS + P0_PS - 1) / P0_PS;
        lo = s0 + 2;
        hi = s0 + 2 + w;
        if (m >= lo + GUARD && m <= hi - GUARD) return 0;
        if (m <= lo - GUARD) return 1;
        if (m >= hi + GUARD) return 2;
        return 3;
    endfunction

    task automatic oneshot(input int s0, input int w, input int s1);
        int cls;
        cls = classify(s0, w, s1);
        wr(1, s0); wr(2, w); wr(3, s1);
        irq_cnt = 0;
        wr(0, 3'b101);               // clear + one-shot start
        for (int i = 0; i < 600 && !done; i++) @(negedge clk_ref);
        idle(2);
        check(done == 1'b1, "R3 one-shot done", int'(done), 1);
        if (cls == 0) begin
            check(err == 1'b0, "R3 pass verdict", int'(err), 0);
            check(irq_cnt == 0, "R6 no pulse on pass", irq_cnt, 0);
        end else if (cls == 1) begin
            check(err == 1'b1, "R4 early verdict", int'(err), 1);
            check(irq_cnt == 1, "R6 one pulse", irq_cnt, 1);
        end else if (cls == 2) begin
            check(err == 1'b1, "R5 late verdict", int'(err), 1);
            check(irq_cnt == 1, "R6 one pulse", irq_cnt, 1);
        end
    endtask

    initial begin
        idle(8);
        rst = 1'b0;
        idle(2);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(err == 1'b0, "R1 reset err", int'(err), 0);
        check(err_irq == 1'b0, "R1 reset irq", int'(err_irq), 0);

        // R1: seeds written but no enable -> nothing happens
        wr(1, 10); wr(2, 4); wr(3, 60);
        idle(200);
        check(err == 1'b0 && done == 1'b0, "R1 no run without enable", int'(err) + int'(done), 0);
        check(irq_cnt == 0, "R1 no pulse without enable", irq_cnt, 0);

        // R3/R4/R5 sweeps over the test seed
        for (int s1 = 0; s1 <= 60; s1++) oneshot(40, 20, s1);
        for (int s1 = 0; s1 <= 40; s1 += 2) oneshot(20, 8, s1);

        // R7: after a one-shot pass, a failing seed must not trigger a rerun
        oneshot(40, 20, 35);
        irq_cnt = 0;
        wr(3, 60);
        idle(300);
        check(err == 1'b0, "R7 no rerun after one-shot", int'(err), 0);
        check(done == 1'b1, "R7 done held", int'(done), 1);
        check(irq_cnt == 0, "R7 no pulse after one-shot", irq_cnt, 0);

        // R8: repeat mode with a good ratio
        wr(3, 35);
        irq_cnt = 0;
        wr(0, 3'b111);               // clear + repeat start
        idle(1500);
        check(err == 1'b0, "R8 repeat passes", int'(err), 0);
        check(done == 1'b0, "R8 done stays low in repeat", int'(done), 0);
        check(irq_cnt == 0, "R8 no pulse in repeat", irq_cnt, 0);

        // R8/R9: new seed taken at next reload, failure halts
        wr(3, 60);
        idle(300);
        check(err == 1'b1, "R8 reload uses new seed", int'(err), 1);
        check(irq_cnt == 1, "R9 one pulse on failure", irq_cnt, 1);
        check(done == 1'b0, "R9 no done in repeat", int'(done), 0);
        idle(1000);
        check(irq_cnt == 1, "R9 halted after failure", irq_cnt, 1);
        check(err == 1'b1, "R10 err sticky", int'(err), 1);

        // R10: clear
        wr(0, 3'b100);
        idle(2);
        check(err == 1'b0 && done == 1'b0, "R10 clear", int'(err) + int'(done), 0);

        // R9: restart resumes
        wr(3, 35);
        irq_cnt = 0;
        wr(0, 3'b011);
        idle(1000);
        check(err == 1'b0 && irq_cnt == 0, "R9 restart runs clean", irq_cnt, 0);

        // R11: stop aborts a run that would fail late
        wr(0, 3'b100);
        wr(3, 60);
        idle(2);
        irq_cnt = 0;
        wr(0, 3'b001);
        idle(20);
        wr(0, 3'b000);
        idle(300);
        check(err == 1'b0, "R11 abort no err", int'(err), 0);
        check(done == 1'b0, "R11 abort no done", int'(done), 0);
        check(irq_cnt == 0, "R11 abort no pulse", irq_cnt, 0);

        // R2: seed registers decoded separately - short seed0 makes s1=30 late
        oneshot(5, 10, 30);

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule